// File: doc/BRIEF.md
# Compressed Configuration Table Loader

This block plays back a byte-coded initialisation table from a ROM-style read port. It turns each table entry into write strobes on one of three targets: an 8-bit-addressed internal register space, a 16-bit-addressed external space, or a single-bit set/clear port. After a `start` pulse it fetches one ROM byte per cycle from address 0. The ROM returns the data one cycle after the read. The block decodes entries back to back until it meets the end marker, then holds `done` until it is started again.

Each entry opens with a control byte. Bits [7:6] choose the write kind: 00 internal, 01 external with a full address, 10 bit operations, 11 external on a fixed page. Bits [5:0] carry the payload length. If bit 5 is set, the length uses the 13-bit long form, and one more byte follows. Next come the address bytes that the kind calls for, then the payload bytes. A whole 128-byte waveform area (four 32-byte slots) can be written by a single long-form external entry.

The FSM states are IDLE, CTRL, CNT, AHI, ALO, DATA and DONE. Its transitions are:
- IDLE/DONE→CTRL on `start`.
- CTRL→DONE on a zero byte.
- CTRL→CNT when bit 5 is set.
- CTRL or CNT→AHI for kind 01.
- CTRL or CNT→ALO for kinds 00 and 11.
- CTRL or CNT→DATA for kind 10 with a nonzero length.
- CTRL or CNT→CTRL for kind 10 with a zero length.
- AHI→ALO.
- ALO→DATA, or ALO→CTRL when the length is zero.
- DATA→CTRL on the last payload byte.

Top module: `cfg_table_loader`

## Requirements
- R1: When reset is active, and after it, the block is idle: `busy`, `done`, `rom_rd` and all three write strobes are 0.
- R2: After `start`, the block reads the ROM at consecutive addresses starting from 0, one address per cycle. It uses each byte exactly once and issues no read past the end marker.
- R3: A control byte of 0x00 ends the table. `done` rises, reads stop, and `done` stays high until the next `start`.
- R4: Kind 00 (control bits [7:6]=00) takes one address byte A. Each payload byte i is written with `iw_en` at internal address (A+i) mod 256.
- R5: Kind 01 takes an address high byte and then a low byte. Payload byte i is written with `xw_en` at that 16-bit address plus i.
- R6: Kind 11 takes one low address byte L. Payload byte i is written with `xw_en` at {PAGE, L}+i, where the sum is 16 bits wide.
- R7: Kind 10 has no address byte. Each payload byte b produces one `bw_en` pulse with `bw_addr`=b[6:0] and `bw_val`=b[7].
- R8: When control bit 5 is 0, the length is control[4:0]. When bit 5 is 1, the length is {control[4:0], next byte}. This allows a 128-entry waveform area to be written from a single entry.
- R9: A non-terminating entry of length 0 produces no write, and the byte after its address bytes is read as a control byte.
- R10: At most one write strobe is high in any cycle. Writes come out in table order. Back-to-back writes from one entry step their address by one.
- R11: A `start` pulse while `busy` is high has no effect on the sequence of writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playback from ROM address 0 |
| rom_rd | output | 1 | ROM read enable |
| rom_addr | output | ROM_AW | ROM read address |
| rom_data | input | 8 | ROM read data, valid the cycle after `rom_rd` |
| busy | output | 1 | Table playback in progress |
| done | output | 1 | End marker reached |
| iw_en | output | 1 | Internal space write strobe |
| iw_addr | output | 8 | Internal space write address |
| iw_data | output | 8 | Internal space write data |
| xw_en | output | 1 | External space write strobe |
| xw_addr | output | 16 | External space write address |
| xw_data | output | 8 | External space write data |
| bw_en | output | 1 | Bit operation strobe |
| bw_addr | output | 7 | Bit address |
| bw_val | output | 1 | Bit value to store |

## Verification
Some properties are checked on every cycle:
- the write strobes are mutually exclusive;
- writes happen only during a run;
- addresses step by one within an entry;
- the ROM address advances by one during a fetch burst;
- `done` stays quiet and is held until `start`.

Other properties only the bench scenarios can show:
- that each payload byte lands at the correct address for its kind;
- that the long-form length is decoded correctly;
- that zero-length entries stay silent;
- that `start` is ignored while busy;
- that a table made only of the end marker finishes after a single read.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
    localparam int BYTE_W = 8;
    localparam int IAW    = 8;
    localparam int XAW    = 16;
    localparam int BAW    = 7;
    localparam int SHORT_W = 5;
    localparam int CNT_W  = SHORT_W + BYTE_W;

    typedef enum logic [1:0] {
        MD_IRAM  = 2'b00,
        MD_XWIDE = 2'b01,
        MD_BIT   = 2'b10,
        MD_XPAGE = 2'b11
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CNT,
        ST_AHI,
        ST_ALO,
        ST_DATA,
        ST_DONE
    } state_e;
endpackage

// File: rtl/cfgld_fetch.sv
module cfgld_fetch #(
    parameter int ROM_AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              enable,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              byte_vld
);
    logic [ROM_AW-1:0] ptr_q;

    assign rom_rd   = enable;
    assign rom_addr = ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q    <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= enable;
            if (restart)
                ptr_q <= '0;
            else if (enable)
                ptr_q <= ptr_q + 1'b1;
        end
    end
endmodule

// File: rtl/cfgld_seq.sv
module cfgld_seq
    import cfgld_pkg::*;
#(
    parameter logic [BYTE_W-1:0] PAGE = 8'hE6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] rom_byte,
    output logic              fetch_en,
    output logic              restart,
    output logic              busy,
    output logic              done,
    output logic              req_vld,
    output mode_e             req_mode,
    output logic [XAW-1:0]    req_addr,
    output logic [BYTE_W-1:0] req_data
);
    state_e             st_q, st_d;
    mode_e              mode_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [XAW-1:0]     addr_q;
    logic               term;
    logic               at_rest;

    function automatic state_e after_hdr(input mode_e m, input logic [CNT_W-1:0] c);
        unique case (m)
            MD_XWIDE: after_hdr = ST_AHI;
            MD_BIT:   after_hdr = (c == '0) ? ST_CTRL : ST_DATA;
            default:  after_hdr = ST_ALO;
        endcase
    endfunction

    assign at_rest = (st_q == ST_IDLE) || (st_q == ST_DONE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        term = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_DONE: if (start) st_d = ST_CTRL;
            ST_CTRL: if (byte_vld) begin
                if (rom_byte == '0) begin
                    st_d = ST_DONE;
                    term = 1'b1;
                end else if (rom_byte[5]) begin
                    st_d = ST_CNT;
                end else begin
                    st_d = after_hdr(mode_e'(rom_byte[7:6]),
                                     {{BYTE_W{1'b0}}, rom_byte[SHORT_W-1:0]});
                end
            end
            ST_CNT:  if (byte_vld) st_d = after_hdr(mode_q, {cnt_q[CNT_W-1:BYTE_W], rom_byte});
            ST_AHI:  if (byte_vld) st_d = ST_ALO;
            ST_ALO:  if (byte_vld) st_d = (cnt_q == '0) ? ST_CTRL : ST_DATA;
            ST_DATA: if (byte_vld && cnt_q == CNT_W'(1)) st_d = ST_CTRL;
            default: st_d = ST_IDLE;
        endcase
    end

    // record datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MD_IRAM;
            cnt_q  <= '0;
            addr_q <= '0;
        end else if (byte_vld) begin
            unique case (st_q)
                ST_CTRL: if (rom_byte != '0) begin
                    mode_q <= mode_e'(rom_byte[7:6]);
                    cnt_q  <= rom_byte[5] ? {rom_byte[SHORT_W-1:0], {BYTE_W{1'b0}}}
                                          : {{BYTE_W{1'b0}}, rom_byte[SHORT_W-1:0]};
                end
                ST_CNT:  cnt_q <= {cnt_q[CNT_W-1:BYTE_W], rom_byte};
                ST_AHI:  addr_q[XAW-1:BYTE_W] <= rom_byte;
                ST_ALO: begin
                    unique case (mode_q)
                        MD_XPAGE: addr_q <= {PAGE, rom_byte};
                        MD_XWIDE: addr_q <= {addr_q[XAW-1:BYTE_W], rom_byte};
                        default:  addr_q <= {{(XAW-BYTE_W){1'b0}}, rom_byte};
                    endcase
                end
                ST_DATA: begin
                    addr_q <= addr_q + 1'b1;
                    cnt_q  <= cnt_q - 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        fetch_en = !at_rest && !term;
        restart  = at_rest && start;
        busy     = !at_rest;
        done     = (st_q == ST_DONE);
        req_vld  = (st_q == ST_DATA) && byte_vld;
        req_mode = mode_q;
        req_addr = addr_q;
        req_data = rom_byte;
    end
endmodule

// File: rtl/cfgld_wport.sv
module cfgld_wport
    import cfgld_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  mode_e             req_mode,
    input  logic [XAW-1:0]    req_addr,
    input  logic [BYTE_W-1:0] req_data,
    output logic              iw_en,
    output logic [IAW-1:0]    iw_addr,
    output logic [BYTE_W-1:0] iw_data,
    output logic              xw_en,
    output logic [XAW-1:0]    xw_addr,
    output logic [BYTE_W-1:0] xw_data,
    output logic              bw_en,
    output logic [BAW-1:0]    bw_addr,
    output logic              bw_val
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iw_en   <= 1'b0;
            xw_en   <= 1'b0;
            bw_en   <= 1'b0;
            iw_addr <= '0;
            iw_data <= '0;
            xw_addr <= '0;
            xw_data <= '0;
            bw_addr <= '0;
            bw_val  <= 1'b0;
        end else begin
            iw_en <= req_vld && (req_mode == MD_IRAM);
            xw_en <= req_vld && (req_mode == MD_XWIDE || req_mode == MD_XPAGE);
            bw_en <= req_vld && (req_mode == MD_BIT);
            if (req_vld) begin
                iw_addr <= req_addr[IAW-1:0];
                iw_data <= req_data;
                xw_addr <= req_addr;
                xw_data <= req_data;
                bw_addr <= req_data[BAW-1:0];
                bw_val  <= req_data[BYTE_W-1];
            end
        end
    end
endmodule

// File: rtl/cfg_table_loader.sv
module cfg_table_loader
    import cfgld_pkg::*;
#(
    parameter int                ROM_AW = 12,
    parameter logic [BYTE_W-1:0] PAGE   = 8'hE6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              rom_rd,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [BYTE_W-1:0] rom_data,
    output logic              busy,
    output logic              done,
    output logic              iw_en,
    output logic [IAW-1:0]    iw_addr,
    output logic [BYTE_W-1:0] iw_data,
    output logic              xw_en,
    output logic [XAW-1:0]    xw_addr,
    output logic [BYTE_W-1:0] xw_data,
    output logic              bw_en,
    output logic [BAW-1:0]    bw_addr,
    output logic              bw_val
);
    logic              fetch_en, restart, byte_vld, req_vld;
    mode_e             req_mode;
    logic [XAW-1:0]    req_addr;
    logic [BYTE_W-1:0] req_data;

    cfgld_fetch #(.ROM_AW(ROM_AW)) fetch_i (
        .clk(clk), .rst_n(rst_n), .restart(restart), .enable(fetch_en),
        .rom_rd(rom_rd), .rom_addr(rom_addr), .byte_vld(byte_vld)
    );

    cfgld_seq #(.PAGE(PAGE)) seq_i (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_vld(byte_vld),
        .rom_byte(rom_data), .fetch_en(fetch_en), .restart(restart),
        .busy(busy), .done(done), .req_vld(req_vld), .req_mode(req_mode),
        .req_addr(req_addr), .req_data(req_data)
    );

    cfgld_wport wport_i (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_mode(req_mode),
        .req_addr(req_addr), .req_data(req_data),
        .iw_en(iw_en), .iw_addr(iw_addr), .iw_data(iw_data),
        .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_val(bw_val)
    );
endmodule

// File: rtl/cfg_table_loader_chk.sv
module cfg_table_loader_chk #(
    parameter int ROM_AW = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              rom_rd,
    input logic [ROM_AW-1:0] rom_addr,
    input logic              busy,
    input logic              done,
    input logic              iw_en,
    input logic [7:0]        iw_addr,
    input logic              xw_en,
    input logic [15:0]       xw_addr,
    input logic              bw_en
);
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iw_en, xw_en, bw_en}));

    a_r10_write_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_en || xw_en || bw_en) |-> busy);

    a_r10_xaddr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (xw_en && $past(xw_en)) |-> (xw_addr == $past(xw_addr) + 16'd1));

    a_r4_iaddr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (iw_en && $past(iw_en)) |-> (iw_addr == $past(iw_addr) + 8'd1));

    a_r2_rom_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_rd && $past(rom_rd)) |-> (rom_addr == $past(rom_addr) + 1'b1));

    a_r3_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rom_rd && !busy));

    a_r3_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
endmodule

bind cfg_table_loader cfg_table_loader_chk #(.ROM_AW(ROM_AW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd),
    .rom_addr(rom_addr), .busy(busy), .done(done), .iw_en(iw_en),
    .iw_addr(iw_addr), .xw_en(xw_en), .xw_addr(xw_addr), .bw_en(bw_en)
);

// File: tb/cfg_table_loader_tb_top.sv
module cfg_table_loader_tb_top;
    localparam int          ROM_AW = 12;
    localparam logic [7:0]  PG     = 8'hE6;
    localparam int          NREC   = 8;
    // {long, kind[1:0], count[12:0], addr[15:0], seed[7:0]}
    localparam logic [39:0] RECS [NREC] = '{
        {1'b0, 2'd0, 13'd5,   16'h0010, 8'h11},
        {1'b0, 2'd1, 13'd128, 16'hE400, 8'h01},
        {1'b0, 2'd2, 13'd4,   16'h0000, 8'h83},
        {1'b0, 2'd3, 13'd3,   16'h0030, 8'h50},
        {1'b0, 2'd1, 13'd0,   16'h1234, 8'h00},
        {1'b0, 2'd0, 13'd3,   16'h00FE, 8'hA0},
        {1'b1, 2'd0, 13'd2,   16'h0040, 8'h22},
        {1'b0, 2'd3, 13'd40,  16'h00F0, 8'h09}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic rom_rd, busy, done, iw_en, xw_en, bw_en, bw_val;
    logic [ROM_AW-1:0] rom_addr;
    logic [7:0] rom_q, iw_addr, iw_data, xw_data;
    logic [15:0] xw_addr;
    logic [6:0] bw_addr;

    always #4 clk = ~clk;

    cfg_table_loader #(.ROM_AW(ROM_AW), .PAGE(PG)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .rom_rd(rom_rd),
        .rom_addr(rom_addr), .rom_data(rom_q), .busy(busy), .done(done),
        .iw_en(iw_en), .iw_addr(iw_addr), .iw_data(iw_data),
        .xw_en(xw_en), .xw_addr(xw_addr), .xw_data(xw_data),
        .bw_en(bw_en), .bw_addr(bw_addr), .bw_val(bw_val)
    );

    logic [7:0] rom [0:(1<<ROM_AW)-1];
    always @(posedge clk) if (rom_rd) rom_q <= rom[rom_addr];

    logic [1:0]  ek [0:1023];
    logic [15:0] ea [0:1023];
    logic [7:0]  ed [0:1023];
    int wp = 0, ne = 0, gi = 0, nchk = 0, nfail = 0;
    int ra = 0, rd_err = 0, nreads = 0, wave_cnt = 0, hit_1234 = 0, onehot_err = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string kreq(input logic [1:0] k);
        case (k)
            2'd0: kreq = "R4";
            2'd1: kreq = "R5";
            2'd2: kreq = "R7";
            default: kreq = "R6";
        endcase
    endfunction

    task automatic put(input logic [7:0] b);
        rom[wp] = b;
        wp++;
    endtask

    task automatic add_rec(input logic [39:0] r);
        logic lng; logic [1:0] k; logic [12:0] c; logic [15:0] a; logic [7:0] s, d;
        {lng, k, c, a, s} = r;
        if (lng || c > 13'd31) begin
            put({k, 1'b1, c[12:8]});   // R8 long form
            put(c[7:0]);
        end else begin
            put({k, 1'b0, c[4:0]});
        end
        case (k)
            2'd0: put(a[7:0]);
            2'd1: begin put(a[15:8]); put(a[7:0]); end
            2'd3: put(a[7:0]);
            default: ;
        endcase
        for (int i = 0; i < int'(c); i++) begin
            d = s + 8'(i * 7);
            put(d);
            ek[ne] = k;
            case (k)
                2'd0: begin ea[ne] = {8'h00, a[7:0] + 8'(i)}; ed[ne] = d; end
                2'd1: begin ea[ne] = a + 16'(i); ed[ne] = d; end
                2'd3: begin ea[ne] = {PG, a[7:0]} + 16'(i); ed[ne] = d; end
                default: begin ea[ne] = {9'd0, d[6:0]}; ed[ne] = {7'd0, d[7]}; end
            endcase
            ne++;
        end
    endtask

    // monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (rom_rd) begin
                if (int'(rom_addr) != ra) rd_err++;
                ra++;
                nreads++;
            end
            if (!$onehot0({iw_en, xw_en, bw_en})) onehot_err++;
            if (iw_en || xw_en || bw_en) begin
                logic [1:0] gk; logic [15:0] ga; logic [7:0] gd;
                if (iw_en) begin gk = 2'd0; ga = {8'h00, iw_addr}; gd = iw_data; end
                else if (xw_en) begin gk = 2'd1; ga = xw_addr; gd = xw_data; end
                else begin gk = 2'd2; ga = {9'd0, bw_addr}; gd = {7'd0, bw_val}; end
                if (xw_en && ga >= 16'hE400 && ga <= 16'hE47F) wave_cnt++;
                if (xw_en && ga == 16'h1234) hit_1234++;
                if (gi >= ne) begin
                    check(1'b0, "R10 extra write", gi, ne);
                end else begin
                    check(gk == ek[gi] || (gk == 2'd1 && ek[gi] == 2'd3), kreq(ek[gi]), int'(gk), int'(ek[gi]));
                    check(ga == ea[gi], kreq(ek[gi]), int'(ga), int'(ea[gi]));
                    check(gd == ed[gi], kreq(ek[gi]), int'(gd), int'(ed[gi]));
                end
                gi++;
            end
        end
    end

    task automatic run(input bit poke, output bit ok);
        int t;
        gi = 0; ra = 0; rd_err = 0; nreads = 0; wave_cnt = 0; hit_1234 = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        ok = 1'b0;
        for (t = 0; t < 20000; t++) begin
            if (done) begin ok = 1'b1; break; end
            if (poke && (t == 10 || t == 60)) start = 1'b1;
            else start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        if (!ok) check(1'b0, "R3 watchdog", t, 0);
    endtask

    initial begin
        #1000000;
        nchk++; nfail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        bit ok;
        for (int i = 0; i < (1 << ROM_AW); i++) rom[i] = 8'h00;
        for (int r = 0; r < NREC; r++) add_rec(RECS[r]);
        put(8'h00);

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!busy && !done && !rom_rd && !iw_en && !xw_en && !bw_en, "R1",
              {busy, done, rom_rd, iw_en, xw_en, bw_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !rom_rd, "R1", {busy, done, rom_rd}, 0);

        run(1'b0, ok);
        check(gi == ne, "R10 write count", gi, ne);
        check(rd_err == 0, "R2 sequential reads", rd_err, 0);
        check(nreads == wp, "R2 read count", nreads, wp);
        check(wave_cnt == 128, "R8 waveform area", wave_cnt, 128);
        check(hit_1234 == 0, "R9 zero-length entry", hit_1234, 0);
        check(onehot_err == 0, "R10 one strobe", onehot_err, 0);
        repeat (5) @(negedge clk);
        check(done && !rom_rd && !busy, "R3 done held", {done, rom_rd, busy}, 3'b100);

        // R11: start pulses during the run are ignored
        run(1'b1, ok);
        check(gi == ne, "R11 write count", gi, ne);
        check(nreads == wp && rd_err == 0, "R11 reads", nreads, wp);

        // R1: reset mid-run returns to idle
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        gi = 0; ra = 0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !done && !rom_rd && !iw_en && !xw_en && !bw_en, "R1 mid-run",
              {busy, done, rom_rd, iw_en, xw_en, bw_en}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: table of only the end marker
        rom[0] = 8'h00;
        ne = 0;
        run(1'b0, ok);
        check(gi == 0, "R3 empty table writes", gi, 0);
        check(nreads == 1, "R3 empty table reads", nreads, 1);
        check(done, "R3 empty table done", done, 1);

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule